// File: doc/BRIEF.md
# Write-Allocate Decision Unit

This unit decides whether a pending store that missed the level-one data cache should bring its line into the cache. It keeps a 64-bit control register with two live fields: a 10-bit ceiling that is scaled by 4 MB, and an enable bit for the 1 MB window between 15 MB and 16 MB. Some memory-mapped I/O cards decode that window, and the enable bit lets software keep allocation out of it. Two other allocate mechanisms, cacheable-page and sector, are evaluated elsewhere. Their results arrive as hint inputs, and either hint overrides a rejection by the ceiling.

Requests arrive on a valid/ready stream. A request moves when `req_valid` and `req_ready` are both high. The unit holds `req_ready` low only while it has a decision that the consumer has not taken (`dec_valid` high and `dec_ready` low). A decision stays valid and unchanged until it is taken with `dec_ready` high. Requests that hit the cache are accepted and produce no decision. Register access is a plain write strobe with a continuously driven read value.

Top module: `wa_decide`

## Requirements
- R1: After reset the control register reads all zero and `dec_valid` is low.
- R2: Reserved register bits (63..32, 21..17 and 15..0) always read zero, and writing ones to them has no effect.
- R3: Register bits 31..22 (ceiling field) and bit 16 (window enable) are written by `cfg_wr` and read back unchanged on `cfg_rdata`.
- R4: With no hint asserted, a missing write allocates exactly when address bits 31..22 are less than the ceiling field. An address at or above field × 4 MB does not allocate.
- R5: A ceiling field of zero never allocates through the ceiling mechanism.
- R6: An address with bits 31..20 equal to 0x00F (15 MB up to 16 MB) allocates through the ceiling mechanism only when bit 16 is 1.
- R7: A missing write with `req_page_hint` or `req_sector_hint` high always allocates, whatever the register holds.
- R8: A request with `req_miss` low is accepted and produces no decision.
- R9: The decision for a missing write appears on `dec_valid`/`dec_alloc` in the cycle after acceptance. While `dec_ready` is low it is held with `dec_alloc` stable, and `req_ready` stays low.
- R10: A register write takes effect for requests accepted in the cycle after the write or later. A request accepted in the same cycle as the write sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Current register value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_addr | input | ADDR_W | Physical address of the write |
| req_miss | input | 1 | Write missed the data cache |
| req_page_hint | input | 1 | Cacheable-page mechanism requests allocate |
| req_sector_hint | input | 1 | Sector mechanism requests allocate |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_alloc | output | 1 | 1 = perform write allocate |

## Verification
The bench uses the default 32-bit address width. With that width the whole 4 GB space can be addressed, so the largest ceiling (4092 MB) and the addresses on either side of it can be checked. The table covers addresses that fall just inside and just outside each ceiling, and addresses on both edges of the 15–16 MB window. It includes a ceiling of 12 MB, which lies below the window. Directed tests add back-pressure on the decision stream and a register write issued in the same cycle as a request.

// File: rtl/wa_pkg.sv
package wa_pkg;
  localparam int CSR_W     = 64;
  localparam int SPAN_W    = 32;   // address bits covered by the ceiling
  localparam int LIMIT_LSB = 22;   // 4 MB granularity
  localparam int LIMIT_W   = SPAN_W - LIMIT_LSB;
  localparam int HOLE_BIT  = 16;
  localparam int HOLE_LSB  = 20;   // 1 MB granularity
  localparam int HOLE_W    = SPAN_W - HOLE_LSB;
  localparam logic [HOLE_W-1:0] HOLE_TAG = HOLE_W'(15);

  typedef struct packed {
    logic [LIMIT_W-1:0] limit;
    logic               hole_en;
  } wa_cfg_t;
endpackage

// File: rtl/wa_csr.sv
module wa_csr
  import wa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wdata,
  output wa_cfg_t          cfg,
  output logic [CSR_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.limit   <= wdata[LIMIT_LSB +: LIMIT_W];
      cfg.hole_en <= wdata[HOLE_BIT];
    end
  end

  always_comb begin
    rdata                        = '0;
    rdata[LIMIT_LSB +: LIMIT_W]  = cfg.limit;
    rdata[HOLE_BIT]              = cfg.hole_en;
  end
endmodule

// File: rtl/wa_judge.sv
module wa_judge
  import wa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  wa_cfg_t           cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              page_hint,
  input  logic              sector_hint,
  output logic              alloc
);
  logic upper_clear;
  logic below;
  logic in_hole;
  logic limit_ok;

  generate
    if (ADDR_W > SPAN_W) begin : g_wide
      assign upper_clear = ~|addr[ADDR_W-1:SPAN_W];
    end else begin : g_narrow
      assign upper_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    below    = upper_clear && (addr[SPAN_W-1:LIMIT_LSB] < cfg.limit);
    in_hole  = upper_clear && (addr[SPAN_W-1:HOLE_LSB] == HOLE_TAG);
    limit_ok = below && (!in_hole || cfg.hole_en);
    alloc    = limit_ok || page_hint || sector_hint;
  end
endmodule

// File: rtl/wa_out_stage.sv
module wa_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_take,
  input  logic in_alloc,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic out_alloc
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_alloc <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid && in_take;
      if (in_valid && in_take) out_alloc <= in_alloc;
    end
  end
endmodule

// File: rtl/wa_decide.sv
module wa_decide
  import wa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_miss,
  input  logic              req_page_hint,
  input  logic              req_sector_hint,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_alloc
);
  wa_cfg_t cfg;
  logic    alloc_now;

  wa_csr u_csr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  wa_judge #(.ADDR_W(ADDR_W)) u_judge (
    .cfg         (cfg),
    .addr        (req_addr),
    .page_hint   (req_page_hint),
    .sector_hint (req_sector_hint),
    .alloc       (alloc_now)
  );

  wa_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_take   (req_miss),
    .in_alloc  (alloc_now),
    .in_ready  (req_ready),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .out_alloc (dec_alloc)
  );
endmodule

// File: rtl/wa_decide_chk.sv
module wa_decide_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] cfg_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_miss,
  input logic        req_page_hint,
  input logic        req_sector_hint,
  input logic        dec_valid,
  input logic        dec_ready,
  input logic        dec_alloc
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[63:32] == '0) && (cfg_rdata[21:17] == '0) && (cfg_rdata[15:0] == '0));

  p_hint_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_miss && (req_page_hint || req_sector_hint)) |=> (dec_valid && dec_alloc));

  p_zero_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_miss && !req_page_hint && !req_sector_hint && (cfg_rdata[31:22] == '0))
      |=> (dec_valid && !dec_alloc));

  p_hit_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_miss) |=> !dec_valid);

  p_miss_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_miss) |=> dec_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_alloc)));

  p_ready_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> req_ready);
endmodule

bind wa_decide wa_decide_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_rdata       (cfg_rdata),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_miss        (req_miss),
  .req_page_hint   (req_page_hint),
  .req_sector_hint (req_sector_hint),
  .dec_valid       (dec_valid),
  .dec_ready       (dec_ready),
  .dec_alloc       (dec_alloc)
);

// File: tb/test_wa_decide.sv
`timescale 1ns/1ps
module test_wa_decide;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_miss = 1'b0;
  logic        req_page_hint = 1'b0;
  logic        req_sector_hint = 1'b0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_alloc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wa_decide #(.ADDR_W(32)) i_wa_decide (.*);

  typedef struct packed {
    logic [9:0]  lim;
    logic        hen;
    logic [31:0] addr;
    logic        miss;
    logic        pg;
    logic        sc;
    logic        exp_v;
    logic        exp_a;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{10'd4,    1'b1, 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 below 16 MB
    '{10'd4,    1'b1, 32'h0100_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 exactly at ceiling
    '{10'd4,    1'b0, 32'h00FF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6}, // R6 window top, disabled
    '{10'd4,    1'b1, 32'h00FF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 window top, enabled
    '{10'd4,    1'b0, 32'h00EF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 just below window
    '{10'd0,    1'b1, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 zero ceiling
    '{10'd0,    1'b0, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 page hint
    '{10'd4,    1'b0, 32'h00F0_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7}, // R7 sector hint in window
    '{10'd1023, 1'b1, 32'hFFBF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 just below 4092 MB
    '{10'd1023, 1'b1, 32'hFFC0_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 at 4092 MB
    '{10'd4,    1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 hit
    '{10'd3,    1'b1, 32'h00F0_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6}  // R6 window above 12 MB ceiling
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [9:0] lim, input logic hen);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = '0;
    cfg_wdata[31:22] = lim;
    cfg_wdata[16] = hen;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 64'h0, "R1 rdata", cfg_rdata, 64'h0);
    chk(dec_valid == 1'b0, "R1 dec_valid", dec_valid, 0);
    rst_n = 1'b1;

    // R2 reserved bits
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = '1;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(cfg_rdata == 64'h0000_0000_FFC1_0000, "R2 reserved", cfg_rdata, 64'h0000_0000_FFC1_0000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(TBL[i].lim, TBL[i].hen);
      chk(cfg_rdata[31:22] == TBL[i].lim && cfg_rdata[16] == TBL[i].hen,
          "R3 readback", cfg_rdata, {32'h0, TBL[i].lim, 5'h0, TBL[i].hen, 16'h0});
      req_valid = 1'b1;
      req_addr = TBL[i].addr;
      req_miss = TBL[i].miss;
      req_page_hint = TBL[i].pg;
      req_sector_hint = TBL[i].sc;
      @(negedge clk);
      req_valid = 1'b0;
      chk(dec_valid == TBL[i].exp_v, $sformatf("R%0d valid vec %0d", TBL[i].req, i), dec_valid, TBL[i].exp_v);
      if (TBL[i].exp_v)
        chk(dec_alloc == TBL[i].exp_a, $sformatf("R%0d alloc vec %0d", TBL[i].req, i), dec_alloc, TBL[i].exp_a);
    end
    req_page_hint = 1'b0;
    req_sector_hint = 1'b0;

    // R10 write in the same cycle as a request uses old value
    wr_reg(10'd0, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 64'h0;
    cfg_wdata[31:22] = 10'd4;
    req_valid = 1'b1;
    req_miss = 1'b1;
    req_addr = 32'h0000_2000;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(dec_valid && !dec_alloc, "R10 same cycle old value", dec_alloc, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(dec_valid && dec_alloc, "R10 next cycle new value", dec_alloc, 1);

    // R9 back-pressure
    @(negedge clk);
    dec_ready = 1'b0;
    req_valid = 1'b1;
    req_addr = 32'h0000_0000;
    @(negedge clk);
    req_addr = 32'h0200_0000;  // would not allocate
    chk(dec_valid && dec_alloc, "R9 first decision", dec_alloc, 1);
    chk(req_ready == 1'b0, "R9 ready low while held", req_ready, 0);
    @(negedge clk);
    chk(dec_valid && dec_alloc, "R9 decision held", dec_alloc, 1);
    dec_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(dec_valid && !dec_alloc, "R9 second decision after release", dec_alloc, 0);
    @(negedge clk);
    chk(!dec_valid, "R9 drained", dec_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule